// File: doc/BRIEF.md
# Exception-Return Status Restore Unit

This unit carries out the status-word and stack-pointer update that a return-from-exception instruction performs. It holds the 32-bit status word, the active stack pointer and the saved kernel stack pointer. When the return strobe arrives, it pops the mode-field stack inside the status word. The two top bits are kept. The low 28-bit field is shifted right by ten places, which moves the previously saved mode bits into the live positions. The pending flag is then set unless the restored R flag asks for it to be kept. If the restored mode is user mode, the unit also swaps stacks.

The surrounding core loads the status word and the stack pointer through two plain write ports. It supplies the user stack pointer as an input and reads the results on the outputs. The results appear in the cycle after the strobe, together with a one-cycle done pulse. When a swap takes place, a swap request carries the old stack pointer out so that it can be stored.

Top module: `rfe_restore_top`

## Requirements
- R1: On a return, bits [31:30] of the new status word equal bits [31:30] of the old one.
- R2: On a return, new status bits [17:0] equal old bits [27:10], and new bits [29:18] are zero. The only exception is bit 7 when R3 applies.
- R3: The R flag is status bit 9 and the P flag is status bit 7. If bit 9 of the new status word is clear, bit 7 of the new status word is 1.
- R4: If bit 9 of the new status word is set, bit 7 of the new status word equals old bit 17 (its plainly shifted value).
- R5: The U flag is status bit 8. If bit 8 of the new status word is set, the following happens in the cycle after the strobe: swapReq is 1, savedSp holds the old sp, kernelSp holds the old sp, and sp holds userSp as sampled at the strobe.
- R6: If bit 8 of the new status word is clear, swapReq stays 0, and sp and kernelSp keep their values.
- R7: done is 1 in exactly the cycle after each return strobe and 0 otherwise. All outputs take their new values in that same cycle.
- R8: While reset is active, status, sp, kernelSp, savedSp, swapReq and done are all zero.
- R9: statusWrEn loads statusWrData into status, and spWrEn loads spWrData into sp, on the next edge. A return strobe in the same cycle takes priority over both write ports, and both writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rfeStb | input | 1 | Return-from-exception strobe |
| statusWrEn | input | 1 | Status word write enable |
| statusWrData | input | 32 | Status word write value |
| spWrEn | input | 1 | Stack pointer write enable |
| spWrData | input | 32 | Stack pointer write value |
| userSp | input | 32 | Current user stack pointer |
| status | output | 32 | Status word |
| sp | output | 32 | Active stack pointer |
| kernelSp | output | 32 | Saved kernel stack pointer |
| swapReq | output | 1 | Stack swap request (one cycle) |
| savedSp | output | 32 | Old stack pointer handed out on a swap |
| done | output | 1 | Return complete pulse |

## Verification
The return is tried with several old status words. An all-ones word shows that the top bits are kept, that the mid field is cleared and that P keeps its shifted value while R is set. An all-zero word shows that P is forced on its own. Separate words with only R, only U, R and U together, and the saved-P bit set tell apart the forced-P rule from the plain shift and the swap path from the no-swap path. A return issued together with both write enables shows that the return wins. Back-to-back returns show that the mode stack pops a second time and that done is a single pulse per strobe.

// File: rtl/rfe_restore_pkg.sv
package rfe_restore_pkg;
  localparam int WordW   = 32;
  localparam int PopSh   = 10;
  localparam int FieldW  = 28;
  localparam int BitP    = 7;
  localparam int BitU    = 8;
  localparam int BitR    = 9;

  typedef struct packed {
    logic doRfe;
    logic doStatusWr;
    logic doSpWr;
  } rfeCtrl_t;
endpackage

// File: rtl/rfe_restore_ctrl.sv
module rfe_restore_ctrl
  import rfe_restore_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rfeStb,
  input  logic     statusWrEn,
  input  logic     spWrEn,
  output rfeCtrl_t ctrl,
  output logic     done
);
  // Return has priority; plain writes are dropped while it runs.
  always_comb begin
    ctrl.doRfe      = rfeStb;
    ctrl.doStatusWr = statusWrEn && !rfeStb;
    ctrl.doSpWr     = spWrEn && !rfeStb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= rfeStb;
  end
endmodule

// File: rtl/rfe_restore_dp.sv
module rfe_restore_dp
  import rfe_restore_pkg::*;
#(
  parameter int W = WordW
) (
  input  logic         clk,
  input  logic         rstN,
  input  rfeCtrl_t     ctrl,
  input  logic [W-1:0] statusWrData,
  input  logic [W-1:0] spWrData,
  input  logic [W-1:0] userSp,
  output logic [W-1:0] statusQ,
  output logic [W-1:0] spQ,
  output logic [W-1:0] kspQ,
  output logic [W-1:0] savedSpQ,
  output logic         swapQ
);
  localparam int KeepW = W - FieldW - 2;

  logic [W-1:0]      popped;
  logic [W-1:0]      nextStatus;
  logic [FieldW-1:0] lowField;

  always_comb begin
    lowField   = statusQ[FieldW-1:0] >> PopSh;
    popped     = '0;
    popped[W-1:W-KeepW]   = statusQ[W-1:W-KeepW];
    popped[FieldW-1:0]    = lowField;
    nextStatus = popped;
    if (!popped[BitR]) nextStatus[BitP] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ  <= '0;
      spQ      <= '0;
      kspQ     <= '0;
      savedSpQ <= '0;
      swapQ    <= 1'b0;
    end else begin
      swapQ <= 1'b0;
      if (ctrl.doRfe) begin
        statusQ <= nextStatus;
        if (popped[BitU]) begin
          kspQ     <= spQ;
          savedSpQ <= spQ;
          spQ      <= userSp;
          swapQ    <= 1'b1;
        end
      end else begin
        if (ctrl.doStatusWr) statusQ <= statusWrData;
        if (ctrl.doSpWr)     spQ     <= spWrData;
      end
    end
  end
endmodule

// File: rtl/rfe_restore_top.sv
module rfe_restore_top
  import rfe_restore_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rfeStb,
  input  logic        statusWrEn,
  input  logic [31:0] statusWrData,
  input  logic        spWrEn,
  input  logic [31:0] spWrData,
  input  logic [31:0] userSp,
  output logic [31:0] status,
  output logic [31:0] sp,
  output logic [31:0] kernelSp,
  output logic        swapReq,
  output logic [31:0] savedSp,
  output logic        done
);
  rfeCtrl_t ctrl;

  rfe_restore_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .rfeStb(rfeStb),
    .statusWrEn(statusWrEn), .spWrEn(spWrEn),
    .ctrl(ctrl), .done(done)
  );

  rfe_restore_dp #(.W(WordW)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .statusWrData(statusWrData), .spWrData(spWrData), .userSp(userSp),
    .statusQ(status), .spQ(sp), .kspQ(kernelSp),
    .savedSpQ(savedSp), .swapQ(swapReq)
  );
endmodule

// File: rtl/rfe_restore_chk.sv
module rfe_restore_chk (
  input logic        clk,
  input logic        rstN,
  input logic        rfeStb,
  input logic [31:0] userSp,
  input logic [31:0] status,
  input logic [31:0] sp,
  input logic [31:0] kernelSp,
  input logic        swapReq,
  input logic [31:0] savedSp,
  input logic        done
);
  p_top_kept_r1: assert property (@(posedge clk) disable iff (!rstN)
    rfeStb |=> status[31:30] == $past(status[31:30]));

  p_field_pop_r2: assert property (@(posedge clk) disable iff (!rstN)
    rfeStb |=> (status[29:18] == 12'h0) && (status[17:8] == $past(status[27:18]))
               && (status[6:0] == $past(status[16:10])));

  p_p_forced_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rfeStb && !status[19]) |=> status[7]);

  p_p_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rfeStb && status[19]) |=> status[7] == $past(status[17]));

  p_swap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rfeStb && status[18]) |=> swapReq && (sp == $past(userSp))
      && (kernelSp == $past(sp)) && (savedSp == $past(sp)));

  p_no_swap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rfeStb && !status[18]) |=> !swapReq && $stable(sp) && $stable(kernelSp));

  p_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    rfeStb |=> done);

  p_done_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rfeStb |=> !done && !swapReq);
endmodule

bind rfe_restore_top rfe_restore_chk chk_i (
  .clk(clk), .rstN(rstN), .rfeStb(rfeStb), .userSp(userSp),
  .status(status), .sp(sp), .kernelSp(kernelSp),
  .swapReq(swapReq), .savedSp(savedSp), .done(done)
);

// File: tb/rfe_restore_tb.sv
`timescale 1ns/1ps
module rfe_restore_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rfeStb = 1'b0;
  logic        statusWrEn = 1'b0;
  logic [31:0] statusWrData = '0;
  logic        spWrEn = 1'b0;
  logic [31:0] spWrData = '0;
  logic [31:0] userSp = '0;
  logic [31:0] status, sp, kernelSp, savedSp;
  logic        swapReq, done;

  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  rfe_restore_top dut_i (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Model of the status update, from R1..R4.
  function automatic logic [31:0] model(input logic [31:0] old);
    logic [31:0] n;
    n = {old[31:30], 2'b00, 10'h000, old[27:10]};
    if (!n[9]) n[7] = 1'b1;
    return n;
  endfunction

  task automatic loadState(input logic [31:0] st, input logic [31:0] s);
    @(negedge clk);
    statusWrEn = 1'b1; statusWrData = st;
    spWrEn = 1'b1;     spWrData = s;
    @(negedge clk);
    statusWrEn = 1'b0; spWrEn = 1'b0;
    chk("R9", "status load", status, st);
    chk("R9", "sp load", sp, s);
  endtask

  // Issue one return and check every output in the following cycle.
  task automatic runRfe(input string tag, input logic [31:0] usp);
    logic [31:0] oldSt, oldSp, oldKsp, expSt;
    logic u;
    oldSt = status; oldSp = sp; oldKsp = kernelSp;
    expSt = model(oldSt);
    u = expSt[8];
    @(negedge clk);
    rfeStb = 1'b1; userSp = usp;
    @(negedge clk);
    rfeStb = 1'b0;
    chk("R1 R2 R3 R4", {tag, " status"}, status, expSt);
    chk("R7", {tag, " done"}, {31'b0, done}, 32'd1);
    if (u) begin
      chk("R5", {tag, " swapReq"}, {31'b0, swapReq}, 32'd1);
      chk("R5", {tag, " sp"}, sp, usp);
      chk("R5", {tag, " kernelSp"}, kernelSp, oldSp);
      chk("R5", {tag, " savedSp"}, savedSp, oldSp);
    end else begin
      chk("R6", {tag, " swapReq"}, {31'b0, swapReq}, 32'd0);
      chk("R6", {tag, " sp"}, sp, oldSp);
      chk("R6", {tag, " kernelSp"}, kernelSp, oldKsp);
    end
    @(negedge clk);
    chk("R7", {tag, " done falls"}, {31'b0, done}, 32'd0);
    chk("R7", {tag, " swap falls"}, {31'b0, swapReq}, 32'd0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R8", "status", status, 32'h0);
    chk("R8", "sp", sp, 32'h0);
    chk("R8", "kernelSp", kernelSp, 32'h0);
    chk("R8", "savedSp", savedSp, 32'h0);
    chk("R8", "swap/done", {30'b0, swapReq, done}, 32'h0);
  endtask

  task automatic testAllOnes();
    loadState(32'hFFFF_FFFF, 32'h1000_0010);
    runRfe("ones", 32'h2000_0020);
    chk("R4", "ones exact", status, 32'hC003_FFFF);
  endtask

  task automatic testZero();
    loadState(32'h0000_0000, 32'h1111_1111);
    runRfe("zero", 32'h5555_5555);
    chk("R3", "zero exact", status, 32'h0000_0080);
  endtask

  task automatic testRonly();
    loadState(32'h800A_0000, 32'h0000_3000);
    runRfe("ronly", 32'hABCD_0000);
    chk("R4", "ronly exact", status, 32'h8000_0280);
  endtask

  task automatic testRandU();
    loadState(32'h400C_0000, 32'h0000_4000);
    runRfe("r_and_u", 32'h0000_7000);
    chk("R4", "r_and_u exact", status, 32'h4000_0300);
  endtask

  task automatic testUonly();
    loadState(32'h0004_0000, 32'h0000_8000);
    runRfe("uonly", 32'h0000_9000);
    chk("R3", "uonly exact", status, 32'h0000_0180);
  endtask

  task automatic testPriority();
    loadState(32'h0004_0000, 32'h0000_A000);
    @(negedge clk);
    rfeStb = 1'b1; userSp = 32'h0000_B000;
    statusWrEn = 1'b1; statusWrData = 32'hDEAD_BEEF;
    spWrEn = 1'b1; spWrData = 32'hCAFE_0000;
    @(negedge clk);
    rfeStb = 1'b0; statusWrEn = 1'b0; spWrEn = 1'b0;
    chk("R9", "rfe wins status", status, 32'h0000_0180);
    chk("R9", "rfe wins sp", sp, 32'h0000_B000);
  endtask

  task automatic testBackToBack();
    // Two nested levels: second return pops the next saved mode.
    loadState(32'h0100_0000 | 32'h0004_0000, 32'h0000_0100);
    runRfe("pop1", 32'h0000_0200);
    chk("R2", "pop1 exact", status, 32'h0000_4180);
    runRfe("pop2", 32'h0000_0300);
    chk("R3", "pop2 exact", status, 32'h0000_0090);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        testReset();
        rstN = 1'b1;
        testAllOnes();
        testZero();
        testRonly();
        testRandU();
        testUonly();
        testPriority();
        testBackToBack();
      end
      begin
        repeat (5000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule